// File: doc/BRIEF.md
# Bus Arbiter Preemption Timer

This block sits next to the arbiter of a shared parallel bus. It decides when the master that owns the bus may lose its grant. The master marks its transfer with an active-high frame signal. A 4-bit delay code selects how many clock cycles must pass after the frame starts before preemption is allowed. A second input tells the block that another master is waiting. The single output, `preempt_en`, tells the arbiter that it may now withdraw the current grant.

The delay code is logarithmic. Code values 0, 1 and 2 give delays of 0, 1 and 2 cycles. Each further step doubles the delay, so code 7 gives 64 cycles. The top bit of the code turns preemption off completely.

The code is captured in the first cycle of each transfer, so a change made while a transfer is running only affects the next one. The cycle counter clears whenever the frame is low. It stops at its largest value, so a very long transfer stays eligible for preemption and never wraps back to a blocked state. In a wider configuration word the code usually sits in bits 31:28; the block itself takes only the four code bits.

Top module: `preempt_timer`

## Requirements
- R1: A synchronous active-high reset clears the block. After reset, or after a reset that occurs during a transfer, the next cycle with `frame_act` high counts as the first cycle of a new transfer. While `frame_act` is low, `preempt_en` is 0.
- R2: When bit 3 of the captured code is 1, `preempt_en` stays 0 for the whole transfer, whatever the value of bits 2:0.
- R3: Let cycle 0 be the first cycle of a transfer, that is, a cycle with `frame_act` high whose preceding cycle had it low. Codes 0000, 0001 and 0010 allow preemption from cycle 0, 1 and 2 respectively. With code 0000, `preempt_en` can therefore be high in cycle 0 itself.
- R4: Codes 0011, 0100, 0101, 0110 and 0111 allow preemption from cycle 4, 8, 16, 32 and 64 respectively.
- R5: `preempt_en` is 1 exactly when all three of the following hold in the same cycle: `frame_act` is high, `req_pend` is high, and the programmed delay has elapsed. It follows `req_pend` cycle by cycle.
- R6: When `frame_act` goes low, the elapsed-cycle count clears. The next assertion of `frame_act` starts the delay again from cycle 0.
- R7: The cycle counter saturates. A transfer that lasts far longer than 64 cycles stays eligible for preemption in every later cycle.
- R8: The code is captured in cycle 0 of a transfer from `ctl_code`. Changes to `ctl_code` in later cycles of the same transfer have no effect until the next transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_code | input | 4 | Delay code; bit 3 = 1 disables preemption |
| frame_act | input | 1 | High while the current master's transfer is in progress |
| req_pend | input | 1 | High when another master is requesting the bus |
| preempt_en | output | 1 | High when the current grant may be withdrawn |

## Verification
Several events can fall in the same cycle, and these coincidences are the hardest cases. The start of a transfer captures the code and restarts the counter. With code 0000, the preemption decision must be made in that same cycle, from the live code rather than a stored one. Scenarios of interest include:
- running code 0000 with a request already pending at the frame edge, so the output is expected high in cycle 0;
- changing `ctl_code` in the cycle right after that edge, which must be ignored;
- a reset during a transfer while the frame is held high, after which the next frame cycle must be treated as a new start.

The output in every cycle is compared with a cycle-by-cycle model of the requirements.

// File: rtl/preempt_pkg.sv
package preempt_pkg;
    localparam int CODE_W    = 4;
    localparam int MAX_EXP   = (1 << (CODE_W - 1)) - 2;
    localparam int MAX_DELAY = 1 << MAX_EXP;
    localparam int CNT_W     = $clog2(MAX_DELAY + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [CNT_W-1:0]  count_t;

    typedef struct packed {
        logic   enable;
        count_t delay;
    } plan_t;

    // Code value s in the low bits: 0 -> 0 cycles, s > 0 -> 2^(s-1) cycles.
    function automatic plan_t decode_code(code_t c);
        plan_t                  p;
        logic [CODE_W-2:0]      s;
        s        = c[CODE_W-2:0];
        p.enable = ~c[CODE_W-1];
        if (s == '0)
            p.delay = '0;
        else
            p.delay = count_t'(1) << (s - 1'b1);
        return p;
    endfunction
endpackage

// File: rtl/preempt_frame_track.sv
module preempt_frame_track
    import preempt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_act,
    output logic   in_xfer,
    output count_t elapsed
);
    localparam count_t SAT = count_t'(MAX_DELAY);

    count_t cnt_q;
    logic   xfer_q;

    always_comb begin
        elapsed = xfer_q ? cnt_q : '0;
        in_xfer = xfer_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= 1'b0;
            cnt_q  <= '0;
        end else if (frame_act) begin
            xfer_q <= 1'b1;
            if (elapsed >= SAT)
                cnt_q <= SAT;
            else
                cnt_q <= elapsed + 1'b1;
        end else begin
            xfer_q <= 1'b0;
            cnt_q  <= '0;
        end
    end
endmodule

// File: rtl/preempt_code_select.sv
module preempt_code_select
    import preempt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_act,
    input  logic  in_xfer,
    input  code_t live_code,
    output code_t lat_code,
    output code_t eff_code
);
    code_t hold_q;

    always_comb begin
        eff_code = in_xfer ? hold_q : live_code;
        lat_code = hold_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (frame_act && !in_xfer)
            hold_q <= live_code;
    end
endmodule

// File: rtl/preempt_gate.sv
module preempt_gate
    import preempt_pkg::*;
(
    input  code_t  eff_code,
    input  count_t elapsed,
    input  logic   frame_act,
    input  logic   req_pend,
    output logic   plan_enable,
    output logic   preempt_en
);
    plan_t plan;
    logic  window_open;

    always_comb begin
        plan        = decode_code(eff_code);
        plan_enable = plan.enable;
        window_open = plan.enable && (elapsed >= plan.delay);
        preempt_en  = window_open && frame_act && req_pend;
    end
endmodule

// File: rtl/preempt_timer.sv
module preempt_timer
    import preempt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] ctl_code,
    input  logic              frame_act,
    input  logic              req_pend,
    output logic              preempt_en
);
    logic   in_xfer;
    count_t elapsed;
    code_t  lat_code;
    code_t  eff_code;
    logic   plan_enable;

    preempt_frame_track u_track (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .in_xfer   (in_xfer),
        .elapsed   (elapsed)
    );

    preempt_code_select u_code (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .in_xfer   (in_xfer),
        .live_code (ctl_code),
        .lat_code  (lat_code),
        .eff_code  (eff_code)
    );

    preempt_gate u_gate (
        .eff_code    (eff_code),
        .elapsed     (elapsed),
        .frame_act   (frame_act),
        .req_pend    (req_pend),
        .plan_enable (plan_enable),
        .preempt_en  (preempt_en)
    );
endmodule

// File: rtl/preempt_timer_chk.sv
module preempt_timer_chk
    import preempt_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input code_t  ctl_code,
    input logic   frame_act,
    input logic   req_pend,
    input logic   preempt_en,
    input logic   in_xfer,
    input count_t elapsed,
    input code_t  lat_code,
    input logic   plan_enable
);
    p_no_frame_r1: assert property (@(posedge clk) disable iff (rst)
        !frame_act |-> !preempt_en);

    p_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        !plan_enable |-> !preempt_en);

    p_zero_delay_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_act && !in_xfer && req_pend && ctl_code == '0) |-> preempt_en);

    p_no_request_r5: assert property (@(posedge clk) disable iff (rst)
        !req_pend |-> !preempt_en);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !frame_act |=> (elapsed == '0));

    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        elapsed <= count_t'(MAX_DELAY));

    p_long_xfer_r7: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && frame_act && req_pend && !lat_code[CODE_W-1]
         && elapsed == count_t'(MAX_DELAY)) |-> preempt_en);

    p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && frame_act) |=> $stable(lat_code));
endmodule

bind preempt_timer preempt_timer_chk chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_code    (ctl_code),
    .frame_act   (frame_act),
    .req_pend    (req_pend),
    .preempt_en  (preempt_en),
    .in_xfer     (in_xfer),
    .elapsed     (elapsed),
    .lat_code    (lat_code),
    .plan_enable (plan_enable)
);

// File: tb/preempt_timer_test.sv
module preempt_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ctl_code = 4'd0;
    logic       frame_act = 1'b0;
    logic       req_pend = 1'b0;
    logic       preempt_en;

    typedef struct {
        bit    skip;
        bit    exp;
        string tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // reference state, built from the requirements
    bit       m_prev = 0;
    int       m_cnt  = 0;
    bit [3:0] m_code = 4'd0;

    preempt_timer uut (
        .clk        (clk),
        .rst        (rst),
        .ctl_code   (ctl_code),
        .frame_act  (frame_act),
        .req_pend   (req_pend),
        .preempt_en (preempt_en)
    );

    always #5 clk = ~clk;

    function automatic int delay_of(bit [3:0] c);
        if (c[2:0] == 3'd0) return 0;
        return 1 << (c[2:0] - 1);
    endfunction

    task automatic cyc(bit r, bit f, bit p, bit [3:0] c, string tag);
        item_t    it;
        int       e;
        bit [3:0] uc;
        @(negedge clk);
        rst = r; frame_act = f; req_pend = p; ctl_code = c;
        it.tag  = tag;
        it.skip = r;
        e  = m_prev ? m_cnt : 0;
        uc = m_prev ? m_code : c;
        it.exp = f && p && !uc[3] && (e >= delay_of(uc));
        q.push_back(it);
        if (r) begin
            m_prev = 0; m_cnt = 0; m_code = 4'd0;
        end else if (f) begin
            m_code = uc;
            m_cnt  = (e >= 64) ? 64 : e + 1;
            m_prev = 1;
        end else begin
            m_prev = 0; m_cnt = 0;
        end
    endtask

    task automatic xfer(bit [3:0] c, int len, string tag);
        for (int i = 0; i < len; i++) cyc(0, 1, 1, c, tag);
        cyc(0, 0, 1, c, tag);
        cyc(0, 0, 0, c, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor / scoreboard
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0) begin
                it = q.pop_front();
                if (!it.skip) begin
                    checks++;
                    if (preempt_en !== it.exp) begin
                        fails++;
                        $display("FAIL %s t=%0t preempt_en actual=%b expected=%b",
                                 it.tag, $time, preempt_en, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset, then idle with a request pending
        cyc(1, 1, 1, 4'd0, "R1");
        cyc(1, 1, 1, 4'd0, "R1");
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 4'd0, "R1");

        // R3 / R4: each enabling code, held past its delay
        for (int c = 0; c < 3; c++) xfer(4'(c), delay_of(4'(c)) + 4, "R3");
        for (int c = 3; c < 8; c++) xfer(4'(c), delay_of(4'(c)) + 4, "R4");

        // R2: top bit set, low bits vary
        for (int c = 8; c < 16; c++) xfer(4'(c), 12, "R2");
        xfer(4'd15, 70, "R2");

        // R5: request toggles during a transfer with code 2
        for (int i = 0; i < 10; i++) cyc(0, 1, (i % 3) != 0, 4'd2, "R5");
        cyc(0, 0, 1, 4'd2, "R5");
        cyc(0, 0, 1, 4'd0, "R5");

        // R6: short frame, gap, new frame restarts the 8-cycle delay
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 4'd4, "R6");
        cyc(0, 0, 1, 4'd4, "R6");
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 4'd4, "R6");
        cyc(0, 0, 0, 4'd4, "R6");

        // R7: long transfer with code 7
        xfer(4'd7, 200, "R7");

        // R8: code changes mid-transfer are ignored
        cyc(0, 1, 1, 4'd6, "R8");
        for (int i = 0; i < 40; i++) cyc(0, 1, 1, 4'd0, "R8");
        cyc(0, 0, 1, 4'd0, "R8");
        cyc(0, 1, 1, 4'd1, "R8");
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 4'd15, "R8");
        cyc(0, 0, 1, 4'd15, "R8");
        cyc(0, 1, 1, 4'd8, "R8");
        for (int i = 0; i < 6; i++) cyc(0, 1, 1, 4'd0, "R8");
        cyc(0, 0, 0, 4'd0, "R8");

        // R1: reset in the middle of a transfer, frame held high
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 4'd3, "R1");
        cyc(1, 1, 1, 4'd3, "R1");
        for (int i = 0; i < 8; i++) cyc(0, 1, 1, 4'd3, "R1");
        cyc(0, 0, 0, 4'd3, "R1");

        repeat (3) @(negedge clk);
        #5;
        done = 1;
        summary();
        $finish;
    end
endmodule